// File: doc/BRIEF.md
# Block Transfer Word Sequencer

This block follows one multi-word transfer on a multiplexed backplane from the local side and drives the per-word buffer control. A transfer opens with a start cycle. During that cycle the word-count code on the address lines and the direction are sampled. Next come data cycles at sequential addresses. The responding side acknowledges every intermediate word on a separate mid-transfer acknowledge line. The last word is closed by an ordinary acknowledge cycle, and that cycle ends the transfer.

For each accepted word the sequencer pulses one of two strobes. In the read direction a capture strobe tells the local buffer to latch the word. In the write direction a request strobe asks local logic for the next word. A word offset counter starts at zero and is exposed so that local memory can build sequential addresses. A code outside the supported set is reported and the block stays idle. An ordinary acknowledge that arrives before the expected count is reached ends the transfer and is marked as short.

Top module: `blk_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o, word_off_o, cap_stb_o, wr_req_o, done_o, code_err_o and short_o are all 0.
- R2: While idle, a start_i with cnt_code_i equal to 4'b0001, 4'b0011, 4'b0111 or 4'b1111 begins a transfer of 2, 4, 8 or 16 words. The cycle after the start, busy_o is 1, word_off_o is 0 and short_o is 0.
- R3: While idle, a start_i with any other code gives a single-cycle code_err_o pulse the cycle after the start, and busy_o stays 0.
- R4: While busy, a mid_ack_i (without end_ack_i) when word_off_o is below count-1 increments word_off_o by one, visible the next cycle.
- R5: In the read direction (rd_i=1 at the start), cap_stb_o pulses for one cycle after each accepted mid_ack_i and after the closing end_ack_i. wr_req_o stays 0.
- R6: In the write direction (rd_i=0 at the start), wr_req_o pulses for one cycle after each accepted mid_ack_i and never after end_ack_i. cap_stb_o stays 0.
- R7: While busy, end_ack_i ends the transfer. The next cycle shows done_o=1 for one cycle and busy_o=0.
- R8: If end_ack_i arrives while word_off_o is below count-1, short_o becomes 1 and holds until the next accepted start. When the full count is reached, short_o is 0.
- R9: A mid_ack_i that arrives when word_off_o already equals count-1 is ignored: the offset is unchanged and no strobe is produced.
- R10: start_i while busy is ignored, and mid_ack_i or end_ack_i while idle is ignored. Neither changes busy_o, word_off_o, the strobes or short_o.
- R11: When mid_ack_i and end_ack_i are both high, end_ack_i takes priority: the transfer ends and word_off_o is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start cycle addressed to this board for a multi-word transfer |
| rd_i | input | 1 | Direction at the start: 1 read, 0 write |
| cnt_code_i | input | 4 | Word-count code from the address lines, sampled at the start |
| mid_ack_i | input | 1 | Acknowledge of an intermediate word |
| end_ack_i | input | 1 | Ordinary acknowledge that closes the transfer |
| busy_o | output | 1 | Transfer in progress |
| word_off_o | output | 4 | Word offset for local address forming |
| cap_stb_o | output | 1 | Read-direction capture strobe |
| wr_req_o | output | 1 | Write-direction next-word request |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| code_err_o | output | 1 | One-cycle unsupported-code pulse |
| short_o | output | 1 | Last transfer ended before its count |

## Verification
The hardest situations to reach from the ports are the edges of the offset range. One is an extra mid acknowledge when the offset is already at count-1. The other is a closing acknowledge that lands in the same cycle as a mid acknowledge. Random stimulus seldom produces either one at the exact offset where it matters. The bench therefore runs directed transfers that count acknowledges up to the last index and then inject the extra or combined acknowledge. Random transfers with early closes, idle-time acknowledges and stray start pulses fill in the rest. A bench reference model checks every cycle.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } seq_state_t;
endpackage

// File: rtl/blk_code_dec.sv
// Word-count code decoder: code (2^k)-1 means 2^k words, k = 1..CNT_W.
// The last offset index equals the code itself.
module blk_code_dec #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] code_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] last_o
);
  logic [CNT_W-1:0] hit;

  for (genvar k = 1; k <= CNT_W; k++) begin : g_size
    localparam logic [CNT_W-1:0] PAT = CNT_W'((1 << k) - 1);
    assign hit[k-1] = (code_i == PAT);
  end

  always_comb begin
    valid_o = |hit;
    last_o  = valid_o ? code_i : '0;
  end
endmodule

// File: rtl/blk_word_ctr.sv
module blk_word_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] off_o
);
  logic [CNT_W-1:0] off_q, off_d;
  logic             off_en;

  always_comb begin
    off_en = clr_i | inc_i;
    off_d  = clr_i ? '0 : off_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign off_o = off_q;
endmodule

// File: rtl/blk_strobe_gen.sv
module blk_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic word_i,
  input  logic last_i,
  input  logic rd_i,
  output logic cap_o,
  output logic wr_o
);
  logic cap_d, wr_d;

  always_comb begin
    cap_d = rd_i & (word_i | last_i);
    wr_d  = ~rd_i & word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o <= 1'b0;
      wr_o  <= 1'b0;
    end else begin
      cap_o <= cap_d;
      wr_o  <= wr_d;
    end
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_o, wr_o}));
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import blk_seq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_code_i,
  input  logic             mid_ack_i,
  input  logic             end_ack_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] word_off_o,
  output logic             cap_stb_o,
  output logic             wr_req_o,
  output logic             done_o,
  output logic             code_err_o,
  output logic             short_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             dir_q, dir_d;
  logic             short_q, short_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             code_ok;
  logic [CNT_W-1:0] code_last;
  logic             accept, word_ev, final_ev, at_last;

  blk_code_dec #(.CNT_W(CNT_W)) u_dec (
    .code_i (cnt_code_i),
    .valid_o(code_ok),
    .last_o (code_last)
  );

  always_comb begin
    at_last  = (word_off_o == last_q);
    accept   = (state_q == ST_IDLE) & start_i & code_ok;
    final_ev = (state_q == ST_XFER) & end_ack_i;
    word_ev  = (state_q == ST_XFER) & mid_ack_i & ~end_ack_i & ~at_last;
  end

  always_comb begin
    state_d = state_q;
    last_d  = last_q;
    dir_d   = dir_q;
    short_d = short_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (code_ok) begin
            state_d = ST_XFER;
            last_d  = code_last;
            dir_d   = rd_i;
            short_d = 1'b0;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_XFER: begin
        if (end_ack_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          short_d = ~at_last;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      last_q  <= '0;
      dir_q   <= 1'b0;
      short_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      last_q  <= last_d;
      dir_q   <= dir_d;
      short_q <= short_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  blk_word_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n_s),
    .clr_i(accept),
    .inc_i(word_ev),
    .off_o(word_off_o)
  );

  blk_strobe_gen u_stb (
    .clk   (clk),
    .rst_n (rst_n_s),
    .word_i(word_ev),
    .last_i(final_ev),
    .rd_i  (dir_q),
    .cap_o (cap_stb_o),
    .wr_o  (wr_req_o)
  );

  assign busy_o     = (state_q == ST_XFER);
  assign done_o     = done_q;
  assign code_err_o = err_q;
  assign short_o    = short_q;

  // R4
  off_step_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && mid_ack_i && !end_ack_i && word_off_o != last_q)
      |=> (word_off_o == $past(word_off_o) + 1'b1));
  // R9
  off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_o |-> (word_off_o <= last_q));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);
  // R3
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    code_err_o |-> !busy_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy_o && !start_i) |=> !busy_o);
  // R11
  end_prio_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && end_ack_i) |=> (!busy_o && $stable(word_off_o)));
endmodule

// File: tb/sim_blk_seq.sv
`timescale 1ns/1ps
module sim_blk_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, rd_i, mid_ack_i, end_ack_i;
  logic [3:0] cnt_code_i;
  logic       busy_o, cap_stb_o, wr_req_o, done_o, code_err_o, short_o;
  logic [3:0] word_off_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic       m_busy, m_rd, m_short;
  logic [3:0] m_off, m_last;
  logic       e_cap, e_wr, e_done, e_err;

  always #2.5 clk = ~clk;

  blk_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .cnt_code_i(cnt_code_i), .mid_ack_i(mid_ack_i), .end_ack_i(end_ack_i),
    .busy_o(busy_o), .word_off_o(word_off_o), .cap_stb_o(cap_stb_o),
    .wr_req_o(wr_req_o), .done_o(done_o), .code_err_o(code_err_o),
    .short_o(short_o)
  );

  function automatic int words_of(input logic [3:0] c);
    case (c)
      4'b0001: return 2;
      4'b0011: return 4;
      4'b0111: return 8;
      4'b1111: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2/R7 busy_o", busy_o, m_busy);
    chk("R4 word_off_o", word_off_o, m_off);
    chk("R5 cap_stb_o", cap_stb_o, e_cap);
    chk("R6 wr_req_o", wr_req_o, e_wr);
    chk("R7 done_o", done_o, e_done);
    chk("R3 code_err_o", code_err_o, e_err);
    chk("R8 short_o", short_o, m_short);
  endtask

  // one cycle: drive at negedge, model, check after the posedge
  task automatic step(input logic s, input logic [3:0] c, input logic r,
                      input logic m, input logic e);
    int w;
    start_i = s; cnt_code_i = c; rd_i = r; mid_ack_i = m; end_ack_i = e;
    e_cap = 0; e_wr = 0; e_done = 0; e_err = 0;
    if (!m_busy) begin
      if (s) begin
        w = words_of(c);
        if (w != 0) begin
          m_busy = 1; m_off = 0; m_last = 4'(w - 1); m_rd = r; m_short = 0;
        end else e_err = 1;
      end
    end else begin
      if (e) begin
        e_done = 1; m_busy = 0; m_short = (m_off != m_last); e_cap = m_rd;
      end else if (m && m_off != m_last) begin
        m_off = m_off + 1'b1;
        if (m_rd) e_cap = 1; else e_wr = 1;
      end
    end
    @(posedge clk);
    #1;
    check_all();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 4'h0, 0, 0, 0);
  endtask

  // full transfer: count mids up to last, then close
  task automatic full_xfer(input logic [3:0] c, input logic r);
    step(1, c, r, 0, 0);
    for (int i = 0; i < words_of(c) - 1; i++) step(0, 4'h0, 0, 1, 0);
    step(0, 4'h0, 0, 0, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_busy = 0; m_rd = 0; m_short = 0; m_off = 0; m_last = 0;
    e_cap = 0; e_wr = 0; e_done = 0; e_err = 0;
    start_i = 0; rd_i = 0; cnt_code_i = 0; mid_ack_i = 0; end_ack_i = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all(); // R1 in reset
    rst_n = 1;
    idle(4);     // R1 after release (synchroniser settles with idle inputs)

    // R2/R5 full 2-word read, R6 full 16-word write
    full_xfer(4'b0001, 1);
    full_xfer(4'b1111, 0);
    full_xfer(4'b0011, 1);
    full_xfer(4'b0111, 0);
    // R3 unsupported codes
    step(1, 4'b0000, 1, 0, 0);
    step(1, 4'b0101, 0, 0, 0);
    step(1, 4'b1110, 0, 0, 0);
    idle(1);
    // R9 extra mid ack at last index, R10 start while busy
    step(1, 4'b0011, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 4'h0, 0, 1, 0);
    step(0, 4'h0, 0, 1, 0);      // R9 ignored
    step(1, 4'b0001, 0, 0, 0);   // R10 ignored
    step(0, 4'h0, 0, 1, 1);      // R11 both: end wins, full count
    // R10 acks while idle
    step(0, 4'h0, 0, 1, 0);
    step(0, 4'h0, 0, 0, 1);
    // R8 short transfer, held through idle, cleared by next start
    step(1, 4'b0111, 0, 0, 0);
    step(0, 4'h0, 0, 1, 0);
    step(0, 4'h0, 0, 1, 1);      // R11 both mid-way: no increment, short
    idle(3);
    step(1, 4'b0110, 0, 0, 0);   // R3 bad code does not clear short
    step(1, 4'b0001, 1, 0, 0);   // R2 clears short
    step(0, 4'h0, 0, 0, 1);      // R8 short again (one of two words)

    // random mix
    for (int t = 0; t < 400; t++) begin
      int gap;
      logic [3:0] c;
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++)
        step(0, 4'h0, 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
      if (($urandom % 5) == 0) c = 4'($urandom);
      else begin
        case ($urandom % 4)
          0: c = 4'b0001;
          1: c = 4'b0011;
          2: c = 4'b0111;
          default: c = 4'b1111;
        endcase
      end
      step(1, c, 1'($urandom), 0, 0);
      for (int k = 0; k < 60 && m_busy; k++) begin
        int r;
        logic e;
        r = $urandom % 16;
        e = (r == 0) || (m_off == m_last && r < 8);
        step(($urandom % 8) == 0, 4'($urandom), 1'($urandom), r < 11, e);
      end
      if (m_busy) step(0, 4'h0, 0, 0, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule